// File: doc/BRIEF.md
# Programmable Divider and Phase Comparator for a Frequency Synthesiser

This block is the digital heart of a phase-locked tuning loop. An external divide-by-8 prescaler feeds an oscillator-derived clock into a 15-bit programmable counter. A fixed counter brings the reference clock down to the comparison rate. A phase-frequency detector then compares the two divided streams. It emits pump-up pulses when the reference event comes first and pump-down pulses when the divided oscillator event comes first. The analog pump and loop amplifier turn these pulses into the tuning voltage. The loop settles when the oscillator runs at ratio × 8 × comparison rate, which is ratio × comparison rate as seen at the prescaled input.

Each divided event is a single-cycle pulse. The oscillator-side event crosses into the reference clock domain through a toggle and a two-flop synchroniser, and all comparison happens in the reference domain. A lock detector watches how wide the pump pulses are and raises a flag after enough consecutive clean comparison periods.

Four control levels shape the outputs:
- one blocks both pump outputs;
- one routes the two comparator inputs onto two port pins for test;
- one selects high pump current;
- one switches the drive amplifier off.

Top module: `pll_divider_core`

## Requirements
- R1: The reference path divides `ref_clk` by REF_DIV (default 512). With `test_en`=1, `p6_test` pulses high for exactly one `ref_clk` cycle once every REF_DIV cycles. A 4 MHz reference therefore gives a 7.8125 kHz comparison rate.
- R2: The oscillator path divides `rf_clk` by `ratio`, and a `ratio` below 2 acts as 2. A new `ratio` is sampled only at the counter's terminal count, so the running cycle always completes.
- R3: When the loop is closed and locked, the `rf_clk` rate equals `ratio` times the comparison rate.
- R4: `pump_up` is driven while the reference event leads, and `pump_dn` is driven while the divided oscillator event leads. The two are never high in the same cycle.
- R5: While `pump_off` is 1, `pump_up` and `pump_dn` are both 0.
- R6: `hi_current` follows `cp_high`, and `drive_en` is the inverse of `drive_off`.
- R7: With `test_en`=1, the comparison-rate pulse appears on `p6_test` and the synchronised divided-oscillator pulse appears on `p7_test`. With `test_en`=0, both are 0.
- R8: `locked` rises after LOCK_CYC (default 4) consecutive comparison periods in which no pump pulse lasts longer than LOCK_TOL (default 4) `ref_clk` cycles. It falls one cycle after a pulse exceeds that width.
- R9: While `rst_n` is low, `pump_up`, `pump_dn`, `locked`, `p6_test` and `p7_test` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| ref_clk | input | 1 | Reference clock |
| rf_clk | input | 1 | Prescaled oscillator clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously per domain |
| ratio | input | 15 | Programmable division ratio |
| pump_off | input | 1 | 1 forces both pump outputs inactive |
| test_en | input | 1 | 1 routes comparator inputs to the test outputs |
| cp_high | input | 1 | Pump current select, passed through |
| drive_off | input | 1 | 1 switches the drive amplifier off |
| pump_up | output | 1 | Pump-up pulse |
| pump_dn | output | 1 | Pump-down pulse |
| hi_current | output | 1 | High pump current select |
| drive_en | output | 1 | Drive amplifier enable |
| locked | output | 1 | Lock flag |
| p6_test | output | 1 | Comparison-rate pulse in test mode |
| p7_test | output | 1 | Divided oscillator pulse in test mode |

## Verification
The bench closes the loop with a behavioural oscillator that speeds up on `pump_up` and slows on `pump_dn`. It then checks that lock is reached, that it is lost after a ratio change, and that it is regained. A detector with swapped pump polarity would never lock, and a lock detector that ignores wide pulses would keep `locked` high after the ratio jump.

Pulse counts on the test outputs expose several faults:
- a reference counter that is off by one;
- a ratio of 0 or 1 that is not clamped to 2, which would stall the divider or speed it past the synchroniser;
- a missing pump gate under `pump_off`.

The bench also counts any cycle with both pump outputs high, which a detector without a shared clear would produce.

// File: rtl/pll_divider_core.sv
module pll_divider_core #(
  parameter int RATIO_W  = 15,
  parameter int REF_DIV  = 512,
  parameter int LOCK_TOL = 4,
  parameter int LOCK_CYC = 4
) (
  input  logic               ref_clk,
  input  logic               rf_clk,
  input  logic               rst_n,
  input  logic [RATIO_W-1:0] ratio,
  input  logic               pump_off,
  input  logic               test_en,
  input  logic               cp_high,
  input  logic               drive_off,
  output logic               pump_up,
  output logic               pump_dn,
  output logic               hi_current,
  output logic               drive_en,
  output logic               locked,
  output logic               p6_test,
  output logic               p7_test
);

  localparam int REF_W  = $clog2(REF_DIV);
  localparam int RUN_W  = $clog2(LOCK_TOL + 2);
  localparam int GOOD_W = (LOCK_CYC > 1) ? $clog2(LOCK_CYC) : 1;
  localparam logic [REF_W-1:0]   REF_LAST  = REF_W'(REF_DIV - 1);
  localparam logic [RUN_W-1:0]   RUN_MAX   = RUN_W'(LOCK_TOL + 1);
  localparam logic [GOOD_W-1:0]  GOOD_LAST = GOOD_W'(LOCK_CYC - 1);
  localparam logic [RATIO_W-1:0] RATIO_MIN = RATIO_W'(2);

  // reset release, one synchroniser per clock domain
  logic [1:0] ref_rst_q, rf_rst_q;
  logic       ref_rst_n, rf_rst_n;

  always_ff @(posedge ref_clk or negedge rst_n)
    if (!rst_n) ref_rst_q <= '0;
    else        ref_rst_q <= {ref_rst_q[0], 1'b1};

  always_ff @(posedge rf_clk or negedge rst_n)
    if (!rst_n) rf_rst_q <= '0;
    else        rf_rst_q <= {rf_rst_q[0], 1'b1};

  assign ref_rst_n = ref_rst_q[1];
  assign rf_rst_n  = rf_rst_q[1];

  // programmable oscillator divider
  logic [RATIO_W-1:0] rf_cnt;
  logic [RATIO_W-1:0] ratio_eff;
  logic               rf_tog;

  assign ratio_eff = (ratio < RATIO_MIN) ? RATIO_MIN : ratio;

  always_ff @(posedge rf_clk or negedge rf_rst_n)
    if (!rf_rst_n) begin
      rf_cnt <= '0;
      rf_tog <= 1'b0;
    end else if (rf_cnt == '0) begin
      rf_cnt <= ratio_eff - RATIO_W'(1);
      rf_tog <= ~rf_tog;
    end else begin
      rf_cnt <= rf_cnt - RATIO_W'(1);
    end

  a_r2_reload_nonzero: assert property (@(posedge rf_clk) disable iff (!rf_rst_n)
    (rf_cnt == '0) |=> (rf_cnt != '0));

  // crossing into the reference domain
  logic [2:0] fdiv_sync;
  logic       fdiv_pulse;

  always_ff @(posedge ref_clk or negedge ref_rst_n)
    if (!ref_rst_n) fdiv_sync <= '0;
    else            fdiv_sync <= {fdiv_sync[1:0], rf_tog};

  assign fdiv_pulse = fdiv_sync[2] ^ fdiv_sync[1];

  // fixed reference divider
  logic [REF_W-1:0] ref_cnt;
  logic             fcomp_q;

  always_ff @(posedge ref_clk or negedge ref_rst_n)
    if (!ref_rst_n) begin
      ref_cnt <= '0;
      fcomp_q <= 1'b0;
    end else begin
      fcomp_q <= (ref_cnt == REF_LAST);
      ref_cnt <= (ref_cnt == REF_LAST) ? '0 : ref_cnt + REF_W'(1);
    end

  a_r1_fcomp_single: assert property (@(posedge ref_clk) disable iff (!ref_rst_n)
    fcomp_q |=> !fcomp_q);

  // phase-frequency detector with shared clear
  logic up_q, dn_q, up_set, dn_set;

  assign up_set = up_q | fcomp_q;
  assign dn_set = dn_q | fdiv_pulse;

  always_ff @(posedge ref_clk or negedge ref_rst_n)
    if (!ref_rst_n) begin
      up_q <= 1'b0;
      dn_q <= 1'b0;
    end else if (up_set && dn_set) begin
      up_q <= 1'b0;
      dn_q <= 1'b0;
    end else begin
      up_q <= up_set;
      dn_q <= dn_set;
    end

  a_r4_no_overlap: assert property (@(posedge ref_clk) disable iff (!ref_rst_n)
    !(up_q && dn_q));

  assign pump_up = up_q & ~pump_off;
  assign pump_dn = dn_q & ~pump_off;

  a_r5_gate_up: assert property (@(posedge ref_clk) disable iff (!ref_rst_n)
    pump_off |-> !pump_up && !pump_dn);

  // lock detector: width of each pump pulse against LOCK_TOL
  logic [RUN_W-1:0]  run_cnt;
  logic [GOOD_W-1:0] good_cnt;
  logic              wide;

  assign wide = (run_cnt == RUN_MAX);

  always_ff @(posedge ref_clk or negedge ref_rst_n)
    if (!ref_rst_n)         run_cnt <= '0;
    else if (!(up_q|dn_q))  run_cnt <= '0;
    else if (!wide)         run_cnt <= run_cnt + RUN_W'(1);

  always_ff @(posedge ref_clk or negedge ref_rst_n)
    if (!ref_rst_n) begin
      good_cnt <= '0;
      locked   <= 1'b0;
    end else if (wide) begin
      good_cnt <= '0;
      locked   <= 1'b0;
    end else if (fcomp_q) begin
      if (good_cnt == GOOD_LAST) locked <= 1'b1;
      else                       good_cnt <= good_cnt + GOOD_W'(1);
    end

  a_r8_drop_on_wide: assert property (@(posedge ref_clk) disable iff (!ref_rst_n)
    wide |=> !locked);

  a_r8_rise_after_count: assert property (@(posedge ref_clk) disable iff (!ref_rst_n)
    $rose(locked) |-> $past(good_cnt) == GOOD_LAST);

  // pass-through controls and test routing
  assign hi_current = cp_high;
  assign drive_en   = ~drive_off;
  assign p6_test    = test_en & fcomp_q;
  assign p7_test    = test_en & fdiv_pulse;

  a_r9_quiet_in_reset: assert property (@(posedge ref_clk)
    !ref_rst_n |-> !locked && !up_q && !dn_q);

endmodule

// File: tb/pll_divider_core_tb_top.sv
module pll_divider_core_tb_top;

  localparam int CLK_PERIOD = 10;
  localparam int RF_HALF    = 40;

  logic        ref_clk = 1'b0;
  logic        rf_clk  = 1'b0;
  logic        rst_n   = 1'b0;
  logic [14:0] ratio   = 15'd64;
  logic        pump_off = 1'b1, test_en = 1'b0, cp_high = 1'b0, drive_off = 1'b0;
  logic        pump_up, pump_dn, hi_current, drive_en, locked, p6_test, p7_test;

  int n_chk = 0;
  int n_bad = 0;
  int rf_edges = 0;
  bit count_rf = 1'b0;

  pll_divider_core dut_i (
    .ref_clk(ref_clk), .rf_clk(rf_clk), .rst_n(rst_n), .ratio(ratio),
    .pump_off(pump_off), .test_en(test_en), .cp_high(cp_high), .drive_off(drive_off),
    .pump_up(pump_up), .pump_dn(pump_dn), .hi_current(hi_current), .drive_en(drive_en),
    .locked(locked), .p6_test(p6_test), .p7_test(p7_test)
  );

  always #(CLK_PERIOD/2) ref_clk = ~ref_clk;

  // behavioural oscillator pulled by the pump outputs
  initial forever begin
    int h;
    h = pump_up ? 30 : (pump_dn ? 60 : RF_HALF);
    #(h) rf_clk = ~rf_clk;
  end

  always @(posedge rf_clk) if (count_rf) rf_edges++;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  endtask

  // counts p6/p7 pulses and pump overlaps over a window of ref cycles
  task automatic window(input int cycles, output int c6, output int c7,
                        output int nup, output int ndn, output int both);
    c6 = 0; c7 = 0; nup = 0; ndn = 0; both = 0;
    for (int i = 0; i < cycles; i++) begin
      @(negedge ref_clk);
      if (p6_test) c6++;
      if (p7_test) c7++;
      if (pump_up) nup++;
      if (pump_dn) ndn++;
      if (pump_up && pump_dn) both++;
    end
  endtask

  // {cp_high, drive_off, exp hi_current, exp drive_en}
  localparam logic [3:0] VEC [4] = '{4'b0001, 4'b0100, 4'b1011, 4'b1110};

  initial begin
    #(CLK_PERIOD*190000);
    n_bad++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    int c6, c7, nu, nd, bo;
    bit got;
    test_en = 1'b1;
    repeat (20) @(negedge ref_clk);
    // R9 outputs quiet during reset
    chk(!pump_up && !pump_dn && !locked && !p6_test && !p7_test, "R9 reset outputs",
        {pump_up, pump_dn, locked, p6_test, p7_test}, 0);
    rst_n = 1'b1;

    // R6 control pass-through table
    foreach (VEC[k]) begin
      cp_high = VEC[k][3]; drive_off = VEC[k][2];
      #1;
      chk(hi_current == VEC[k][1], "R6 hi_current", hi_current, VEC[k][1]);
      chk(drive_en == VEC[k][0], "R6 drive_en", drive_en, VEC[k][0]);
    end
    cp_high = 1'b0; drive_off = 1'b0;

    repeat (600) @(negedge ref_clk);
    // R1 comparison pulses, R2 divide by 32 at nominal 80ns, R5 pumps gated
    ratio = 15'd32;
    repeat (600) @(negedge ref_clk);
    window(4096, c6, c7, nu, nd, bo);
    chk(c6 == 8, "R1 comparison pulse count", c6, 8);
    chk(c7 >= 15 && c7 <= 17, "R2 ratio 32 pulse count", c7, 16);
    chk(nu == 0 && nd == 0, "R5 pumps gated", nu + nd, 0);

    // R2 ratio below 2 behaves as 2
    ratio = 15'd1;
    repeat (100) @(negedge ref_clk);
    window(4096, c6, c7, nu, nd, bo);
    chk(c7 >= 255 && c7 <= 257, "R2 ratio 1 clamp", c7, 256);
    ratio = 15'd0;
    repeat (100) @(negedge ref_clk);
    window(4096, c6, c7, nu, nd, bo);
    chk(c7 >= 255 && c7 <= 257, "R2 ratio 0 clamp", c7, 256);

    // R7 test outputs silent when test mode off
    test_en = 1'b0;
    window(2048, c6, c7, nu, nd, bo);
    chk(c6 == 0 && c7 == 0, "R7 test outputs off", c6 + c7, 0);
    test_en = 1'b1;

    // R8 R4 close the loop with ratio 64
    ratio = 15'd64;
    pump_off = 1'b0;
    got = 1'b0;
    for (int i = 0; i < 80000 && !got; i++) begin
      @(negedge ref_clk);
      if (locked) got = 1'b1;
    end
    chk(got, "R8 lock reached", got, 1);
    repeat (2048) @(negedge ref_clk);
    count_rf = 1'b1;
    window(4096, c6, c7, nu, nd, bo);
    count_rf = 1'b0;
    chk(rf_edges >= 508 && rf_edges <= 516, "R3 locked rf rate", rf_edges, 512);
    chk(bo == 0, "R4 no pump overlap while locked", bo, 0);
    chk(locked, "R8 lock held", locked, 1);

    // R8 ratio jump breaks lock; R4 pumps active, never together
    ratio = 15'd80;
    window(4 * 512, c6, c7, nu, nd, bo);
    chk(!locked, "R8 lock lost after ratio jump", locked, 0);
    chk(nu + nd > 0, "R4 pumps respond to error", nu + nd, 1);
    chk(bo == 0, "R4 no pump overlap while slewing", bo, 0);

    // R8 relock after return
    ratio = 15'd64;
    got = 1'b0;
    for (int i = 0; i < 80000 && !got; i++) begin
      @(negedge ref_clk);
      if (locked) got = 1'b1;
    end
    chk(got, "R8 relock", got, 1);

    // R5 pump gate with loop open again
    pump_off = 1'b1;
    window(1024, c6, c7, nu, nd, bo);
    chk(nu == 0 && nd == 0, "R5 pumps gated late", nu + nd, 0);

    finish_run();
  end

endmodule